// File: doc/BRIEF.md
# Paged Address Relocation Unit

This block sits on the address path between a 16-bit processor and an 18-bit physical memory. Each processor access carries a virtual address, a privilege mode and an access kind. The block picks one page register pair from the set that belongs to that mode and to the space the access uses: instruction fetches use the instruction space, and data reads and writes use the data space. It adds the page base to the block number of the address and checks the access against the page's length, its growth direction and its access code. One clock later it returns either a relocated physical address or an abort with a set of fault flags.

The first fault after a clear is held in a status record. Later faults do not change that record until a clear request empties it. When relocation is switched off, addresses pass through unchanged, except that the top 8 KiB of the virtual space is placed at the top of the physical space. A write port loads page bases and descriptors, and a combinational read port returns them. Software learns through the read port whether a page has been written to.

Top module: `page_reloc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every response and status output goes to 0, and every base and descriptor goes to 0. A reset descriptor therefore has access code 00, which means non-resident.
- R2: With `reloc_en` high, a request that does not fault gives `rsp_valid`=1 and `rsp_pa` = ((base + va[12:6]) mod 4096) * 64 + va[5:0] one clock after the request. Here va[15:13] selects the page.
- R3: Mode codes are 00 kernel, 01 supervisor and 11 user, and each mode has its own pages. Kind 00 is an instruction fetch and uses the instruction space. Kinds 01 (read), 10 (write) and 11 (read) use the data space. Mode code 10 has no pages, so any relocated request with mode 10 faults as non-resident.
- R4: `rsp_flags` has bit 2 for non-resident, bit 1 for length and bit 0 for protection. Access code 00 faults every kind, with only bit 2 set. Code 01 (read-only) faults writes with bit 0. Code 10 (execute-only) faults reads and writes with bit 0. Code 11 allows all kinds.
- R5: When the direction bit is 0 (upward), a block number greater than the length field faults with bit 1. When it is 1 (downward), a block number less than the length field faults with bit 1. A block number equal to the length field never causes a length fault.
- R6: A faulting request gives `rsp_abort`=1 and `rsp_pa`=0. The length and protection flags may both be set by the same request.
- R7: With `reloc_en` low, no request faults. `rsp_pa` = va, and bits 17:16 are 11 when va[15:13]=111 and 00 otherwise.
- R8: A relocated write that does not fault sets the written-into bit (descriptor bit 6) of the page it used. A faulting write leaves that bit unchanged. A descriptor write through the write port clears it, and this takes priority in the same cycle.
- R9: A fault while `st_flags` is 0 stores the flags, the raw mode, the space (1 = data) and the page into `st_*` at the response edge. Later faults leave the stored values unchanged. `stat_clr` empties the record, and a clear wins over a capture in the same cycle.
- R10: A write with `wr_desc`=0 loads the base from `wr_data[11:0]`. A write with `wr_desc`=1 loads the length from [14:8], the direction from [3] and the access code from [1:0]. `rd_data` returns these fields combinationally in the same positions, with the written-into bit at [6] and all other bits 0. Writes with mode 10 are ignored, and reads with mode 10 return 0.
- R11: In a cycle after a clock with no request, `rsp_valid`, `rsp_abort`, `rsp_flags` and `rsp_pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reloc_en | input | 1 | Relocation and protection enable |
| req_valid | input | 1 | Access request present this cycle |
| req_mode | input | 2 | Privilege mode of the request |
| req_kind | input | 2 | Access kind: fetch, read or write |
| req_va | input | 16 | Virtual address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_pa | output | 18 | Physical address, 0 on abort |
| rsp_abort | output | 1 | Request aborted |
| rsp_flags | output | 3 | Fault flags: non-resident, length, protection |
| stat_clr | input | 1 | Empty the fault status record |
| st_flags | output | 3 | Stored flags of the first fault |
| st_mode | output | 2 | Stored mode of the first fault |
| st_dspace | output | 1 | Stored space of the first fault, 1 = data |
| st_page | output | 3 | Stored page of the first fault |
| wr_en | input | 1 | Page register write strobe |
| wr_mode | input | 2 | Mode of the register written |
| wr_dspace | input | 1 | Space of the register written |
| wr_page | input | 3 | Page of the register written |
| wr_desc | input | 1 | 1 = descriptor, 0 = base |
| wr_data | input | 16 | Write data |
| rd_mode | input | 2 | Mode of the register read |
| rd_dspace | input | 1 | Space of the register read |
| rd_page | input | 3 | Page of the register read |
| rd_desc | input | 1 | 1 = descriptor, 0 = base |
| rd_data | output | 16 | Read data, combinational |

## Verification
Every response output and every status output is due one rising edge after the request that causes it. A written-into bit set by a write, or a register loaded through the write port, is visible on the combinational `rd_data` from that same edge onward. The bench drives one request and one register operation per cycle just after a falling edge. It updates its behavioural model for that rising edge and compares all outputs at the next falling edge. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/pru_pkg.sv
// Package: shared encodings for the paged address relocation unit.
// Assumes a 2-bit mode code in which one value (2'b10) has no page set.
package pru_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_XO   = 2'b10,
        ACC_RW   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READX = 2'b11
    } kind_e;

    localparam int FLAG_NONRES = 2;
    localparam int FLAG_LEN    = 1;
    localparam int FLAG_PROT   = 0;
    localparam int NSETS       = 3;

    // Map a mode code to {valid, set index}
    function automatic logic [2:0] mode_to_set(input logic [1:0] mode);
        case (mode)
            2'b00:   return 3'b100;
            2'b01:   return 3'b101;
            2'b11:   return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pru_page_file.sv
// Page register file: holds base and descriptor per mode, space and page.
// Provides one lookup port, one write port and one combinational read port.
// Assumes the descriptor field layout fits within VA_W bits.
module pru_page_file
    import pru_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PA_W      = 18,
    parameter int PAGE_BITS = 3,
    parameter int OFF_BITS  = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [1:0]                           wr_mode,
    input  logic                                 wr_dspace,
    input  logic [PAGE_BITS-1:0]                 wr_page,
    input  logic                                 wr_desc,
    input  logic [VA_W-1:0]                      wr_data,
    input  logic [1:0]                           lk_mode,
    input  logic                                 lk_dspace,
    input  logic [PAGE_BITS-1:0]                 lk_page,
    input  logic                                 lk_wset,
    output logic                                 lk_ok,
    output logic [PA_W-OFF_BITS-1:0]             lk_base,
    output logic [VA_W-PAGE_BITS-OFF_BITS-1:0]   lk_len,
    output logic                                 lk_dir,
    output logic [1:0]                           lk_acc,
    input  logic [1:0]                           rd_mode,
    input  logic                                 rd_dspace,
    input  logic [PAGE_BITS-1:0]                 rd_page,
    input  logic                                 rd_desc,
    output logic [VA_W-1:0]                      rd_data
);
    localparam int NPAGES   = 1 << PAGE_BITS;
    localparam int BLK_BITS = VA_W - PAGE_BITS - OFF_BITS;
    localparam int BASE_W   = PA_W - OFF_BITS;
    localparam int NENT     = NSETS * 2 * NPAGES;
    localparam int IDX_W    = $clog2(NENT);
    localparam int LEN_LSB  = 8;
    localparam int W_BIT    = 6;
    localparam int DIR_BIT  = 3;

    logic [BASE_W-1:0]   base_q [NENT];
    logic [BLK_BITS-1:0] len_q  [NENT];
    logic                dir_q  [NENT];
    logic [1:0]          acc_q  [NENT];
    logic                w_q    [NENT];

    logic [2:0]       wr_set, lk_set, rd_set;
    logic [IDX_W-1:0] wr_idx, lk_idx, rd_idx;

    function automatic logic [IDX_W-1:0] entry(input logic [1:0] s, input logic d,
                                               input logic [PAGE_BITS-1:0] p);
        return IDX_W'((int'(s) * 2 + int'(d)) * NPAGES + int'(p));
    endfunction

    // Decode the three ports into flat entry indices
    always_comb begin
        wr_set = mode_to_set(wr_mode);
        lk_set = mode_to_set(lk_mode);
        rd_set = mode_to_set(rd_mode);
        wr_idx = entry(wr_set[1:0], wr_dspace, wr_page);
        lk_idx = entry(lk_set[1:0], lk_dspace, lk_page);
        rd_idx = entry(rd_set[1:0], rd_dspace, rd_page);
    end

    // Lookup port feeding the checker and the adder
    always_comb begin
        lk_ok   = lk_set[2];
        lk_base = base_q[lk_idx];
        lk_len  = len_q[lk_idx];
        lk_dir  = dir_q[lk_idx];
        lk_acc  = acc_q[lk_idx];
    end

    // Software read port, zero for the mode without pages
    always_comb begin
        rd_data = '0;
        if (rd_set[2]) begin
            if (rd_desc) begin
                rd_data[LEN_LSB +: BLK_BITS] = len_q[rd_idx];
                rd_data[W_BIT]               = w_q[rd_idx];
                rd_data[DIR_BIT]             = dir_q[rd_idx];
                rd_data[1:0]                 = acc_q[rd_idx];
            end else begin
                rd_data[BASE_W-1:0] = base_q[rd_idx];
            end
        end
    end

    // Register storage: reset, written-into update, then port writes (last wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                base_q[e] <= '0;
                len_q[e]  <= '0;
                dir_q[e]  <= 1'b0;
                acc_q[e]  <= ACC_NONE;
                w_q[e]    <= 1'b0;
            end
        end else begin
            if (lk_wset && lk_ok) w_q[lk_idx] <= 1'b1;
            if (wr_en && wr_set[2]) begin
                if (wr_desc) begin
                    len_q[wr_idx] <= wr_data[LEN_LSB +: BLK_BITS];
                    dir_q[wr_idx] <= wr_data[DIR_BIT];
                    acc_q[wr_idx] <= wr_data[1:0];
                    w_q[wr_idx]   <= 1'b0;
                end else begin
                    base_q[wr_idx] <= wr_data[BASE_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/pru_check.sv
// Access checker: derives the fault flags for one relocated access.
// Assumes set_ok is low for the mode code that has no pages.
module pru_check
    import pru_pkg::*;
#(
    parameter int BLK_BITS = 7
) (
    input  logic                set_ok,
    input  logic [1:0]          kind,
    input  logic [1:0]          acc,
    input  logic                dir,
    input  logic [BLK_BITS-1:0] len,
    input  logic [BLK_BITS-1:0] blk,
    output logic [2:0]          flags
);
    // Non-resident masks the other two checks
    always_comb begin
        flags = '0;
        if (!set_ok || acc == ACC_NONE) begin
            flags[FLAG_NONRES] = 1'b1;
        end else begin
            flags[FLAG_LEN]  = dir ? (blk < len) : (blk > len);
            flags[FLAG_PROT] = (acc == ACC_RO && kind == KIND_WRITE) ||
                               (acc == ACC_XO && kind != KIND_FETCH);
        end
    end

endmodule

// File: rtl/pru_map.sv
// Address former: base plus block number, or pass-through when disabled.
// Assumes PA_W exceeds VA_W; the sum wraps at the physical space size.
module pru_map #(
    parameter int VA_W      = 16,
    parameter int PA_W      = 18,
    parameter int PAGE_BITS = 3,
    parameter int OFF_BITS  = 6
) (
    input  logic                         reloc_en,
    input  logic [VA_W-1:0]              va,
    input  logic [PA_W-OFF_BITS-1:0]     base,
    output logic [PA_W-1:0]              pa
);
    localparam int BLK_BITS = VA_W - PAGE_BITS - OFF_BITS;
    localparam int BASE_W   = PA_W - OFF_BITS;

    logic [BASE_W-1:0] blk_sum;
    logic              top_region;

    // Form the physical address for both modes
    always_comb begin
        blk_sum    = base + BASE_W'(va[OFF_BITS +: BLK_BITS]);
        top_region = &va[VA_W-1 -: PAGE_BITS];
        if (reloc_en) pa = {blk_sum, va[OFF_BITS-1:0]};
        else          pa = {{(PA_W-VA_W){top_region}}, va};
    end

endmodule

// File: rtl/page_reloc_unit.sv
// Top: paged address relocation with per-mode, per-space page registers.
// One clock from request to response; first fault held until cleared.
// Assumes one request per cycle and no back-pressure.
module page_reloc_unit
    import pru_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PA_W      = 18,
    parameter int PAGE_BITS = 3,
    parameter int OFF_BITS  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reloc_en,
    input  logic                 req_valid,
    input  logic [1:0]           req_mode,
    input  logic [1:0]           req_kind,
    input  logic [VA_W-1:0]      req_va,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_pa,
    output logic                 rsp_abort,
    output logic [2:0]           rsp_flags,
    input  logic                 stat_clr,
    output logic [2:0]           st_flags,
    output logic [1:0]           st_mode,
    output logic                 st_dspace,
    output logic [PAGE_BITS-1:0] st_page,
    input  logic                 wr_en,
    input  logic [1:0]           wr_mode,
    input  logic                 wr_dspace,
    input  logic [PAGE_BITS-1:0] wr_page,
    input  logic                 wr_desc,
    input  logic [VA_W-1:0]      wr_data,
    input  logic [1:0]           rd_mode,
    input  logic                 rd_dspace,
    input  logic [PAGE_BITS-1:0] rd_page,
    input  logic                 rd_desc,
    output logic [VA_W-1:0]      rd_data
);
    localparam int BLK_BITS = VA_W - PAGE_BITS - OFF_BITS;
    localparam int BASE_W   = PA_W - OFF_BITS;

    logic                 dspace, lk_ok, lk_dir, wset;
    logic [BASE_W-1:0]    lk_base;
    logic [BLK_BITS-1:0]  lk_len;
    logic [1:0]           lk_acc;
    logic [2:0]           chk_flags, flags_c;
    logic [PA_W-1:0]      pa_c;
    logic [PAGE_BITS-1:0] page;

    assign dspace = (req_kind != KIND_FETCH);
    assign page   = req_va[VA_W-1 -: PAGE_BITS];

    pru_page_file #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS)) u_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_mode(wr_mode), .wr_dspace(wr_dspace), .wr_page(wr_page),
        .wr_desc(wr_desc), .wr_data(wr_data),
        .lk_mode(req_mode), .lk_dspace(dspace), .lk_page(page), .lk_wset(wset),
        .lk_ok(lk_ok), .lk_base(lk_base), .lk_len(lk_len), .lk_dir(lk_dir), .lk_acc(lk_acc),
        .rd_mode(rd_mode), .rd_dspace(rd_dspace), .rd_page(rd_page), .rd_desc(rd_desc),
        .rd_data(rd_data)
    );

    pru_check #(.BLK_BITS(BLK_BITS)) u_check (
        .set_ok(lk_ok), .kind(req_kind), .acc(lk_acc), .dir(lk_dir), .len(lk_len),
        .blk(req_va[OFF_BITS +: BLK_BITS]), .flags(chk_flags)
    );

    pru_map #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS)) u_map (
        .reloc_en(reloc_en), .va(req_va), .base(lk_base), .pa(pa_c)
    );

    // Faults only exist with relocation on; clean writes mark the page
    always_comb begin
        flags_c = reloc_en ? chk_flags : 3'b000;
        wset    = req_valid && reloc_en && req_kind == KIND_WRITE && flags_c == 3'b000;
    end

    // Response register: one clock after the request, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_abort <= 1'b0;
            rsp_flags <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_abort <= req_valid && (flags_c != 3'b000);
            rsp_flags <= req_valid ? flags_c : 3'b000;
            rsp_pa    <= (req_valid && flags_c == 3'b000) ? pa_c : '0;
        end
    end

    // Status record: capture the first fault, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || stat_clr) begin
            st_flags  <= '0;
            st_mode   <= '0;
            st_dspace <= 1'b0;
            st_page   <= '0;
        end else if (req_valid && flags_c != 3'b000 && st_flags == 3'b000) begin
            st_flags  <= flags_c;
            st_mode   <= req_mode;
            st_dspace <= dspace;
            st_page   <= page;
        end
    end

endmodule

// File: rtl/pru_chk.sv
// Checker: port-level properties of the relocation unit, bound to the top.
module pru_chk #(
    parameter int VA_W = 16,
    parameter int PA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reloc_en,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_abort,
    input logic [2:0]      rsp_flags,
    input logic            stat_clr,
    input logic [2:0]      st_flags
);
    // R6
    abort_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (rsp_pa == '0 && rsp_flags != 3'b000));

    // R4
    nonres_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flags[2] |-> rsp_flags[1:0] == 2'b00);

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !reloc_en) |-> (!rsp_abort && rsp_pa[VA_W-1:0] == $past(req_va)));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flags != 3'b000 && !stat_clr) |=> $stable(st_flags));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_abort && rsp_flags == 3'b000 && rsp_pa == '0));

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

endmodule

bind page_reloc_unit pru_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_pru_chk (
    .clk(clk), .rst_n(rst_n), .reloc_en(reloc_en), .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort), .rsp_flags(rsp_flags),
    .stat_clr(stat_clr), .st_flags(st_flags)
);

// File: tb/tb_page_reloc_unit.sv
`timescale 1ns/1ps
module tb_page_reloc_unit;
    logic clk = 0;
    logic rst_n = 0;
    logic reloc_en = 0, req_valid = 0, stat_clr = 0, wr_en = 0, wr_dspace = 0, wr_desc = 0;
    logic rd_dspace = 0, rd_desc = 0;
    logic [1:0] req_mode = 0, req_kind = 0, wr_mode = 0, rd_mode = 0;
    logic [15:0] req_va = 0, wr_data = 0;
    logic [2:0] wr_page = 0, rd_page = 0;
    logic rsp_valid, rsp_abort, st_dspace;
    logic [17:0] rsp_pa;
    logic [2:0] rsp_flags, st_flags, st_page;
    logic [1:0] st_mode;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    page_reloc_unit dut (.*);

    int checks = 0, errors = 0;
    int m_base [3][2][8];
    int m_len [3][2][8];
    int m_dir [3][2][8];
    int m_acc [3][2][8];
    int m_w [3][2][8];
    logic e_valid, e_abort, e_sd;
    logic [17:0] e_pa;
    logic [2:0] e_fl, e_sf, e_sp;
    logic [1:0] e_sm;
    logic [15:0] e_rd;

    function automatic int setidx(input logic [1:0] m);
        if (m == 2'b00) return 0;
        if (m == 2'b01) return 1;
        if (m == 2'b11) return 2;
        return -1;
    endfunction

    function automatic logic [15:0] dsc(input int len, input int dir, input int acc);
        logic [15:0] d = '0;
        d[14:8] = 7'(len);
        d[3] = dir[0];
        d[1:0] = 2'(acc);
        return d;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict, let the edge pass, compare at the falling edge
    task automatic tick(input string tag);
        int si, pg, blk, rs;
        bit sp;
        e_valid = req_valid; e_pa = '0; e_fl = '0; e_abort = 0;
        si = setidx(req_mode); sp = (req_kind != 2'b00);
        pg = int'(req_va[15:13]); blk = int'(req_va[12:6]);
        if (req_valid) begin
            if (!reloc_en) begin
                e_pa = {(req_va[15:13] == 3'b111) ? 2'b11 : 2'b00, req_va};
            end else begin
                if (si < 0) e_fl = 3'b100;
                else if (m_acc[si][sp][pg] == 0) e_fl = 3'b100;
                else begin
                    if (m_dir[si][sp][pg] == 1 ? blk < m_len[si][sp][pg] : blk > m_len[si][sp][pg]) e_fl[1] = 1;
                    if ((m_acc[si][sp][pg] == 1 && req_kind == 2'b10) ||
                        (m_acc[si][sp][pg] == 2 && req_kind != 2'b00)) e_fl[0] = 1;
                end
                if (e_fl == 0) e_pa = 18'((((m_base[si][sp][pg] + blk) % 4096) * 64) + int'(req_va[5:0]));
            end
            e_abort = (e_fl != 0);
        end
        if (stat_clr) begin
            e_sf = 0; e_sm = 0; e_sd = 0; e_sp = 0;
        end else if (req_valid && e_fl != 0 && e_sf == 0) begin
            e_sf = e_fl; e_sm = req_mode; e_sd = sp; e_sp = 3'(pg);
        end
        if (req_valid && reloc_en && req_kind == 2'b10 && e_fl == 0) m_w[si][sp][pg] = 1;
        if (wr_en && setidx(wr_mode) >= 0) begin
            si = setidx(wr_mode);
            if (wr_desc) begin
                m_len[si][wr_dspace][wr_page] = int'(wr_data[14:8]);
                m_dir[si][wr_dspace][wr_page] = int'(wr_data[3]);
                m_acc[si][wr_dspace][wr_page] = int'(wr_data[1:0]);
                m_w[si][wr_dspace][wr_page] = 0;
            end else m_base[si][wr_dspace][wr_page] = int'(wr_data[11:0]);
        end
        rs = setidx(rd_mode); e_rd = '0;
        if (rs >= 0) begin
            if (rd_desc) begin
                e_rd = dsc(m_len[rs][rd_dspace][rd_page], m_dir[rs][rd_dspace][rd_page], m_acc[rs][rd_dspace][rd_page]);
                e_rd[6] = m_w[rs][rd_dspace][rd_page][0];
            end else e_rd = 16'(m_base[rs][rd_dspace][rd_page]);
        end
        @(negedge clk);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk(tag, "rsp_pa", 32'(rsp_pa), 32'(e_pa));
        chk(tag, "rsp_abort", 32'(rsp_abort), 32'(e_abort));
        chk(tag, "rsp_flags", 32'(rsp_flags), 32'(e_fl));
        chk(tag, "status", {23'd0, st_flags, st_mode, st_dspace, st_page},
                           {23'd0, e_sf, e_sm, e_sd, e_sp});
        chk(tag, "rd_data", 32'(rd_data), 32'(e_rd));
        req_valid = 0; wr_en = 0; stat_clr = 0;
    endtask

    task automatic do_wr(input logic [1:0] m, input logic d, input int p, input logic ds,
                         input logic [15:0] data, input string tag);
        wr_en = 1; wr_mode = m; wr_dspace = d; wr_page = 3'(p); wr_desc = ds; wr_data = data;
        rd_mode = m; rd_dspace = d; rd_page = 3'(p); rd_desc = ds;
        tick(tag);
    endtask

    task automatic do_acc(input logic [1:0] m, input logic [1:0] k, input logic [15:0] va, input string tag);
        req_valid = 1; req_mode = m; req_kind = k; req_va = va;
        rd_mode = m; rd_dspace = (k != 2'b00); rd_page = va[15:13]; rd_desc = 1;
        tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 3; a++) for (int b = 0; b < 2; b++) for (int c = 0; c < 8; c++) begin
            m_base[a][b][c] = 0; m_len[a][b][c] = 0; m_dir[a][b][c] = 0; m_acc[a][b][c] = 0; m_w[a][b][c] = 0;
        end
        e_sf = 0; e_sm = 0; e_sd = 0; e_sp = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "rsp_pa", 32'(rsp_pa), 0);
        chk("R1", "st_flags", 32'(st_flags), 0);
        rd_desc = 1;
        #1 chk("R1", "rd_data", 32'(rd_data), 0);
        rst_n = 1;
        reloc_en = 1;
        // R1 default descriptors are non-resident
        do_acc(2'b00, 2'b01, 16'h0040, "R1");
        stat_clr = 1; tick("R9");
        // R10 register loads and readback
        do_wr(2'b00, 1, 1, 0, 16'hF100, "R10");
        do_wr(2'b00, 1, 1, 1, dsc(127, 0, 3), "R10");
        do_wr(2'b00, 0, 0, 0, 16'h0040, "R10");
        do_wr(2'b00, 0, 0, 1, dsc(10, 0, 2), "R10");
        do_wr(2'b00, 1, 2, 0, 16'h0FF0, "R10");
        do_wr(2'b00, 1, 2, 1, dsc(127, 0, 3), "R10");
        // R10 writes with mode 10 are ignored and read back as zero
        do_wr(2'b10, 1, 1, 0, 16'h0ABC, "R10");
        rd_mode = 2'b00; rd_dspace = 1; rd_page = 1; rd_desc = 0; tick("R10");
        // R2 relocation, several patterns and wrap
        do_acc(2'b00, 2'b01, 16'h2000, "R2");
        do_acc(2'b00, 2'b01, 16'h3FFF, "R2");
        do_acc(2'b00, 2'b01, 16'h2A5C, "R2");
        do_acc(2'b00, 2'b01, 16'h4805, "R2");
        // R3 instruction vs data space, mode separation, mode 10
        do_acc(2'b00, 2'b00, 16'h0085, "R3");
        do_acc(2'b00, 2'b01, 16'h0085, "R3");
        stat_clr = 1; tick("R9");
        do_wr(2'b11, 1, 1, 0, 16'h0200, "R3");
        do_wr(2'b11, 1, 1, 1, dsc(127, 0, 3), "R3");
        do_acc(2'b11, 2'b11, 16'h2047, "R3");
        do_acc(2'b01, 2'b01, 16'h2047, "R3");
        do_acc(2'b10, 2'b00, 16'h2047, "R3");
        stat_clr = 1; tick("R9");
        // R4 access codes
        do_wr(2'b01, 1, 3, 0, 16'h0300, "R4");
        do_wr(2'b01, 1, 3, 1, dsc(127, 0, 1), "R4");
        do_acc(2'b01, 2'b01, 16'h6010, "R4");
        do_acc(2'b01, 2'b10, 16'h6010, "R4");
        stat_clr = 1; tick("R9");
        do_acc(2'b00, 2'b01, 16'h0001, "R4");
        do_acc(2'b00, 2'b00, 16'h0001, "R4");
        stat_clr = 1; tick("R9");
        // R5 length, both directions, at and beyond the limit
        do_acc(2'b00, 2'b00, 16'h0280, "R5");
        do_acc(2'b00, 2'b00, 16'h02C0, "R5");
        stat_clr = 1; tick("R9");
        do_wr(2'b00, 1, 4, 0, 16'h0400, "R5");
        do_wr(2'b00, 1, 4, 1, dsc(100, 1, 3), "R5");
        do_acc(2'b00, 2'b01, 16'h8000 | (16'd100 << 6), "R5");
        do_acc(2'b00, 2'b01, 16'h8000 | (16'd99 << 6), "R5");
        do_acc(2'b00, 2'b01, 16'h8000 | (16'd127 << 6), "R5");
        stat_clr = 1; tick("R9");
        // R6 length and protection together
        do_wr(2'b01, 1, 5, 1, dsc(0, 0, 1), "R6");
        do_acc(2'b01, 2'b10, 16'hA000 | (16'd5 << 6), "R6");
        stat_clr = 1; tick("R9");
        // R7 pass-through, including top region, on a non-resident page
        reloc_en = 0;
        do_acc(2'b00, 2'b10, 16'hE123, "R7");
        do_acc(2'b10, 2'b01, 16'h1234, "R7");
        reloc_en = 1;
        // R8 written-into bit
        do_acc(2'b00, 2'b10, 16'h2044, "R8");
        do_acc(2'b01, 2'b10, 16'h6010, "R8");
        stat_clr = 1; tick("R9");
        do_wr(2'b00, 1, 1, 1, dsc(127, 0, 3), "R8");
        do_acc(2'b00, 2'b10, 16'h2044, "R8");
        req_valid = 1; req_mode = 2'b00; req_kind = 2'b10; req_va = 16'h2044;
        wr_en = 1; wr_mode = 2'b00; wr_dspace = 1; wr_page = 1; wr_desc = 1; wr_data = dsc(127, 0, 3);
        rd_mode = 2'b00; rd_dspace = 1; rd_page = 1; rd_desc = 1;
        tick("R8");
        // R9 freeze on first fault, then clear winning over capture
        do_acc(2'b10, 2'b01, 16'h0000, "R9");
        do_acc(2'b01, 2'b10, 16'h6010, "R9");
        req_valid = 1; req_mode = 2'b00; req_kind = 2'b01; req_va = 16'h0001; stat_clr = 1;
        tick("R9");
        do_acc(2'b01, 2'b10, 16'hA140, "R9");
        // R11 idle cycles
        tick("R11");
        tick("R11");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule